// File: doc/BRIEF.md
# Peripheral Clock Gate Controller with Set/Clear Registers

This block holds the on/off state of 64 peripheral clock gates, arranged as two banks of 32. Software never rewrites a whole gate word. Instead, it writes a mask to a set register to switch clocks on, or to a clear register to switch them off. Bits written as zero leave their gates alone. Because of this, two drivers that each own different clocks can never undo each other's changes.

Each bank shows two views of its gates:
- The **request** view holds the state software last asked for.
- The **status** view holds the state the gates have actually reached. It follows the request after a fixed synchroniser delay, so a driver polls status until it matches the request.

Each gate-enable output is the status bit of its clock. A clock's ID selects both its bank (ID / 32) and its bit within that bank (ID mod 32).

Top module: `pclk_gate_ctrl`

## Requirements
- R1: A write of mask M to a bank's set register (bank 0 at 0x24, bank 1 at 0x34) turns on every request bit where M is 1 and leaves every other request bit unchanged.
- R2: A write of mask M to a bank's clear register (bank 0 at 0x28, bank 1 at 0x38) turns off every request bit where M is 1 and leaves every other request bit unchanged.
- R3: Clock ID n belongs to bank n/32 at bit n mod 32. Its gate is `gate_en[n]`.
- R4: Reading a bank's request register (bank 0 at 0x2C, bank 1 at 0x3C) returns that bank's request word. The read data is valid combinationally in the same cycle that `bus_rd` is high.
- R5: The request register changes only on a write to that bank's set or clear register.
- R6: Reading a bank's status register (bank 0 at 0x30, bank 1 at 0x40) returns the request word as it stood exactly SYNC_DEPTH (default 3) clock edges earlier.
- R7: Clock IDs 32 to 35, 55 and 57 are reserved. In bank 1 these are bits 0 to 3, 23 and 25. Their request and status bits always read 0, and set writes cannot turn them on.
- R8: Reading a set or clear address, or any unmapped address, returns 0. Writes to request or status addresses change nothing.
- R9: After reset, all request bits, status bits and gate outputs are 0, except clock ID 2, which is 1.
- R10: `gate_en` always equals {bank 1 status, bank 0 status}.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| gate_en | output | 64 | Gate enable, one bit per clock ID |

## Verification
A set or clear write is applied on the rising edge where `bus_wr` is high. The request readback therefore shows the new value at the following falling edge. The status readback and `gate_en` keep the old value at the next two falling edges and show the new value at the third, so the bench checks both sides of that edge.

Reads are combinational. The bench drives the address at a falling edge and samples one time unit later, with no clock edge in between. A cycle-accurate bench model of the request word and its delay line is checked against `gate_en` at every falling edge during constrained random traffic.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_BANKS  = 2;
  localparam int unsigned BANK_BASE  = 'h24;
  localparam int unsigned BANK_PITCH = 'h10;

  // register order inside a bank is fixed by the address map
  typedef enum logic [1:0] {
    SEL_SET  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  function automatic int unsigned reg_addr(input int unsigned bank, input reg_sel_e sel);
    return BANK_BASE + bank * BANK_PITCH + 4 * int'(sel);
  endfunction

  // bits that no gate exists behind
  function automatic logic [WORD_W-1:0] rsvd_mask(input int unsigned bank);
    return (bank == 1) ? 32'h0280_000F : 32'h0000_0000;
  endfunction

  // gates that come up running (static memory controller clock)
  function automatic logic [WORD_W-1:0] boot_mask(input int unsigned bank);
    return (bank == 0) ? 32'h0000_0004 : 32'h0000_0000;
  endfunction

  function automatic logic [WORD_W-1:0] apply_set(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] m,
                                                  input logic [WORD_W-1:0] rsvd);
    return (cur | m) & ~rsvd;
  endfunction

  function automatic logic [WORD_W-1:0] apply_clr(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] m);
    return cur & ~m;
  endfunction
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  output logic [NUM_BANKS-1:0] set_we,
  output logic [NUM_BANKS-1:0] clr_we,
  output logic [NUM_BANKS-1:0] req_re,
  output logic [NUM_BANKS-1:0] stat_re
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign set_we[b]  = wr && (addr == ADDR_W'(reg_addr(b, SEL_SET)));
    assign clr_we[b]  = wr && (addr == ADDR_W'(reg_addr(b, SEL_CLR)));
    assign req_re[b]  = rd && (addr == ADDR_W'(reg_addr(b, SEL_REQ)));
    assign stat_re[b] = rd && (addr == ADDR_W'(reg_addr(b, SEL_STAT)));
  end
endmodule

// File: rtl/pcg_bank.sv
module pcg_bank
  import pcg_pkg::*;
#(
  parameter int unsigned BANK_IDX   = 0,
  parameter int unsigned SYNC_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] req_o,
  output logic [WORD_W-1:0] stat_o
);
  localparam logic [WORD_W-1:0] RSVD = rsvd_mask(BANK_IDX);
  localparam logic [WORD_W-1:0] BOOT = boot_mask(BANK_IDX) & ~RSVD;

  logic [WORD_W-1:0]                 req_q;
  logic [SYNC_DEPTH-1:0][WORD_W-1:0] stage_q;
  logic [SYNC_DEPTH:0][WORD_W-1:0]   chain;

  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= BOOT;
    else if (set_we) req_q <= apply_set(req_q, wdata, RSVD);
    else if (clr_we) req_q <= apply_clr(req_q, wdata);
  end

  // synchroniser model: request walks SYNC_DEPTH flops to reach status
  assign chain = {stage_q, req_q};

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= {SYNC_DEPTH{BOOT}};
    else        stage_q <= chain[SYNC_DEPTH-1:0];
  end

  assign req_o  = req_q;
  assign stat_o = stage_q[SYNC_DEPTH-1];
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SYNC_DEPTH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [WORD_W-1:0]             bus_wdata,
  input  logic                          bus_rd,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic [NUM_BANKS*WORD_W-1:0]   gate_en
);
  logic [NUM_BANKS-1:0]              set_we, clr_we, req_re, stat_re;
  logic [NUM_BANKS-1:0][WORD_W-1:0]  grp_req, grp_stat;
  logic [WORD_W-1:0]                 rdata_mux;

  pcg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .set_we(set_we), .clr_we(clr_we), .req_re(req_re), .stat_re(stat_re)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pcg_bank #(.BANK_IDX(b), .SYNC_DEPTH(SYNC_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[b]), .clr_we(clr_we[b]), .wdata(bus_wdata),
      .req_o(grp_req[b]), .stat_o(grp_stat[b])
    );
    assign gate_en[b*WORD_W +: WORD_W] = grp_stat[b];
  end

  always_comb begin
    rdata_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (req_re[b])  rdata_mux = rdata_mux | grp_req[b];
      if (stat_re[b]) rdata_mux = rdata_mux | grp_stat[b];
    end
  end

  assign bus_rdata = rdata_mux;
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic [WORD_W-1:0]            bus_wdata,
  input logic                         bus_rd,
  input logic [WORD_W-1:0]            bus_rdata,
  input logic [NUM_BANKS-1:0]         set_we,
  input logic [NUM_BANKS-1:0]         clr_we,
  input logic [NUM_BANKS-1:0][WORD_W-1:0] grp_req,
  input logic [NUM_BANKS-1:0][WORD_W-1:0] grp_stat
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // R1
    set_reaches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> ((grp_req[b] & $past(bus_wdata & ~rsvd_mask(b))) ==
                     $past(bus_wdata & ~rsvd_mask(b))));
    // R1
    set_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we[b] |=> (((grp_req[b] ^ $past(grp_req[b])) & ~$past(bus_wdata)) == '0));
    // R2
    clr_reaches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> ((grp_req[b] & $past(bus_wdata)) == '0));
    // R2
    clr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we[b] |=> (((grp_req[b] ^ $past(grp_req[b])) & ~$past(bus_wdata)) == '0));
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we[b] || clr_we[b]) |=> $stable(grp_req[b]));
    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grp_req[b] | grp_stat[b]) & rsvd_mask(b)) == '0);
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

bind pclk_gate_ctrl pcg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .set_we(set_we), .clr_we(clr_we),
  .grp_req(grp_req), .grp_stat(grp_stat)
);

// File: tb/sim_pclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pclk_gate_ctrl;
  localparam int LAG = 3;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] gate_en;

  int checks = 0, errors = 0;
  bit done = 0, live = 0;

  pclk_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .gate_en(gate_en)
  );

  always #5 clk = ~clk;

  // address map and masks restated from the requirements
  function automatic logic [7:0] a_of(int bank, int kind); // kind 0 set 1 clr 2 req 3 stat
    return 8'h24 + 8'(bank * 16) + 8'(kind * 4);
  endfunction
  function automatic logic [31:0] no_gate(int bank);
    logic [31:0] m = '0;
    if (bank == 1) begin
      foreach (m[i]) if (i < 4 || i == 55 - 32 || i == 57 - 32) m[i] = 1'b1;
    end
    return m;
  endfunction

  // model: requested word plus a LAG-deep history of it
  logic [31:0] mreq [2];
  logic [31:0] hist [2][LAG];

  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!rst_n) begin
        mreq[b] <= (b == 0) ? 32'h4 : 32'h0;
        for (int s = 0; s < LAG; s++) hist[b][s] <= (b == 0) ? 32'h4 : 32'h0;
      end else begin
        if (bus_wr && bus_addr == a_of(b, 0)) mreq[b] <= (mreq[b] | bus_wdata) & ~no_gate(b);
        else if (bus_wr && bus_addr == a_of(b, 1)) mreq[b] <= mreq[b] & ~bus_wdata;
        hist[b][0] <= mreq[b];
        for (int s = 1; s < LAG; s++) hist[b][s] <= hist[b][s-1];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1;
    #1;
    chk(bus_rdata == exp, req, {32'h0, bus_rdata}, {32'h0, exp});
    bus_rd = 0;
  endtask

  // R10 R6: gate outputs track the delayed model every cycle
  always @(negedge clk) begin
    if (live && rst_n)
      chk(gate_en == {hist[1][LAG-1], hist[0][LAG-1]}, "R10/R6 gate_en", gate_en,
          {hist[1][LAG-1], hist[0][LAG-1]});
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1957));
    repeat (4) @(negedge clk);
    rst_n = 1;
    live = 1;
    // R9 reset state
    rd_chk(a_of(0, 2), 32'h4, "R9 req0");
    rd_chk(a_of(0, 3), 32'h4, "R9 stat0");
    rd_chk(a_of(1, 2), 32'h0, "R9 req1");
    rd_chk(a_of(1, 3), 32'h0, "R9 stat1");
    chk(gate_en == 64'h4, "R9 gate_en", gate_en, 64'h4);

    // R1 + R6 exact lag
    wr(a_of(0, 0), 32'h0000_0120);
    rd_chk(a_of(0, 2), 32'h124, "R1 R4 req0 after set");
    rd_chk(a_of(0, 3), 32'h4, "R6 stat0 lag edge1");
    @(negedge clk); rd_chk(a_of(0, 3), 32'h4, "R6 stat0 lag edge2");
    @(negedge clk); rd_chk(a_of(0, 3), 32'h4, "R6 stat0 lag edge3");
    @(negedge clk); rd_chk(a_of(0, 3), 32'h124, "R6 stat0 arrived");
    chk(gate_en[8] && gate_en[5] && gate_en[2], "R10 gate bits 2,5,8", gate_en, 64'h124);

    // R2 clear one bit, keep the others
    wr(a_of(0, 1), 32'h0000_0020);
    rd_chk(a_of(0, 2), 32'h104, "R2 req0 after clear");

    // R3 clock ID 42 sits in bank 1 bit 10
    wr(a_of(1, 0), 32'h1 << (42 % 32));
    repeat (LAG) @(negedge clk);
    chk(gate_en[42] == 1'b1, "R3 id42 gate", gate_en, 64'h1 << 42);
    rd_chk(a_of(1, 2), 32'h400, "R3 req1 bit10");

    // R7 reserved bits
    wr(a_of(1, 0), 32'hFFFF_FFFF);
    rd_chk(a_of(1, 2), ~no_gate(1), "R7 req1 all set");
    repeat (LAG) @(negedge clk);
    rd_chk(a_of(1, 3), 32'hFD7F_FFF0, "R7 stat1 all set");
    wr(a_of(1, 1), 32'hFFFF_FFFF);
    rd_chk(a_of(1, 2), 32'h0, "R2 req1 all clear");

    // R8 write-only / read-only addresses and holes
    rd_chk(a_of(0, 0), 32'h0, "R8 read set0");
    rd_chk(a_of(1, 1), 32'h0, "R8 read clr1");
    rd_chk(8'h00, 32'h0, "R8 read hole");
    wr(a_of(0, 2), 32'hFFFF_FFFF);
    rd_chk(a_of(0, 2), 32'h104, "R8 R5 write req0 ignored");
    wr(a_of(0, 3), 32'h0);
    rd_chk(a_of(0, 2), 32'h104, "R8 R5 write stat0 ignored");
    repeat (LAG) @(negedge clk);
    rd_chk(a_of(0, 3), 32'h104, "R8 stat0 unchanged");

    // R11 idle read bus
    bus_addr = a_of(0, 2); #1;
    chk(bus_rdata == 32'h0, "R11 rdata idle", {32'h0, bus_rdata}, 64'h0);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 5);
      int b  = $urandom_range(0, 1);
      logic [31:0] m = $urandom() & $urandom();
      case (op)
        0, 1: wr(a_of(b, 0), m);           // R1
        2:    wr(a_of(b, 1), m);           // R2
        3:    begin @(negedge clk); rd_chk(a_of(b, 2), mreq[b], "R4 rand req"); end
        4:    begin @(negedge clk); rd_chk(a_of(b, 3), hist[b][LAG-1], "R6 rand stat"); end
        default: wr(8'(($urandom_range(0, 15)) * 4), m);
      endcase
    end

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule